// File: doc/BRIEF.md
# Port Status LED Pattern Driver

This block drives the single status lamp of a powered-Ethernet source port. It takes the port sequencer's two-bit state code, a pulse that the sequencer raises once per detection probe cycle, and a one-millisecond tick. From these it produces an active-low LED drive. While the port is hunting for a valid load, the lamp blinks slowly. Each probe cycle strobe restarts the blink phase, so the lamp edges stay aligned with the probing. While power is delivered, the lamp is lit steadily. During a fault, the lamp blinks fast at 10 Hz.

There are two fault codes. A timed fault shows the fast blink for a fixed hold time and then falls back to the slow search blink by itself, even if the code does not change. A latched fault keeps the fast blink for as long as the code is present. All pattern decisions are taken on tick cycles only. A code change, a strobe or an expiring hold therefore shows at the output on the clock edge that samples the next tick. When the lamp moves into a different pattern, that pattern always starts with the lamp on.

Top module: `port_led_driver`

## Requirements
- R1: The LED output is active low (0 = lit). While reset is asserted and until the first tick after reset, `led_n` is 1.
- R2: With state code 2'b00 (searching), the LED is lit for SLOW_ON_MS ticks starting at each phase restart and is then dark until the next restart.
- R3: A `det_strobe` pulse in any cycle since the previous tick, or in the tick cycle itself, restarts the slow phase at that tick when the slow pattern is shown: the LED is lit at that tick. A strobe in any other pattern is discarded at the tick.
- R4: With state code 2'b01 (powered), the LED is continuously lit.
- R5: With state code 2'b11 (latched fault), the LED blinks with FAST_HALF_MS ticks lit then FAST_HALF_MS ticks dark, starting lit, for as long as the code is held, including past HOLD_MS ticks.
- R6: With state code 2'b10 (timed fault), the fast blink is shown for HOLD_MS ticks from the first tick that sees the code. At the next tick the slow pattern starts, lit, although the code is still 2'b10.
- R7: A new state code or strobe takes effect only at a tick. `led_n` changes only on the clock edge that samples `tick_ms` high.
- R8: On any tick where the shown pattern (slow, steady, fast) differs from the previous one, the new pattern restarts its phase with the LED lit.
- R9: Leaving state code 2'b10 and returning to it later restarts the full HOLD_MS fault hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| det_strobe | input | 1 | One-cycle pulse at the start of each detection probe cycle |
| state_code | input | 2 | Port state: 00 searching, 01 powered, 10 timed fault, 11 latched fault |
| led_n | output | 1 | LED drive, low lights the lamp |

## Verification
The hardest case to reach is the end of the timed fault hold. The code must sit at 2'b10 for two thousand ticks without a break, and only then does the lamp quietly switch to the slow pattern with no input change. A second hard case is returning to 2'b10 after a short absence, which must start a fresh hold. The stimulus reaches both with directed segments that hold each fault code beyond HOLD_MS. It also mixes in random segments, some of them longer than the hold, with stray strobes falling between ticks and on tick cycles.

// File: rtl/port_led_pkg.sv
package port_led_pkg;

    typedef enum logic [1:0] {
        CODE_SEARCH        = 2'b00,
        CODE_POWERED       = 2'b01,
        CODE_FAULT_TIMED   = 2'b10,
        CODE_FAULT_LATCHED = 2'b11
    } code_e;

    typedef enum logic [1:0] {
        PAT_DARK   = 2'd0,
        PAT_SLOW   = 2'd1,
        PAT_STEADY = 2'd2,
        PAT_FAST   = 2'd3
    } pat_e;

endpackage

// File: rtl/port_led_strobe.sv
module port_led_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic det_strobe,
    output logic strobe_seen
);
    typedef struct packed {
        logic pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        strobe_seen = st_q.pend | det_strobe;
        if (tick_ms) begin
            st_d.pend = 1'b0;
        end else begin
            st_d.pend = strobe_seen;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/port_led_hold.sv
module port_led_hold
    import port_led_pkg::*;
#(
    parameter int HOLD_MS = 2000,
    localparam int HW     = $clog2(HOLD_MS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic [1:0] state_code,
    output pat_e       pat_nxt,
    output pat_e       pat_cur
);
    localparam logic [HW-1:0] HOLD_END = HW'(HOLD_MS);

    typedef struct packed {
        code_e         code;
        logic [HW-1:0] hold;
        pat_e          pat;
    } st_t;

    st_t   st_d, st_q;
    code_e code_in;

    always_comb begin
        st_d    = st_q;
        code_in = code_e'(state_code);
        if (tick_ms) begin
            st_d.code = code_in;
            if (code_in == CODE_FAULT_TIMED) begin
                if (st_q.code != CODE_FAULT_TIMED) begin
                    st_d.hold = '0;
                end else if (st_q.hold == HOLD_END) begin
                    st_d.hold = st_q.hold;
                end else begin
                    st_d.hold = st_q.hold + 1'b1;
                end
            end else begin
                st_d.hold = '0;
            end
            case (code_in)
                CODE_SEARCH:        st_d.pat = PAT_SLOW;
                CODE_POWERED:       st_d.pat = PAT_STEADY;
                CODE_FAULT_LATCHED: st_d.pat = PAT_FAST;
                default:            st_d.pat = (st_d.hold == HOLD_END) ? PAT_SLOW : PAT_FAST;
            endcase
        end
        pat_nxt = st_d.pat;
        pat_cur = st_q.pat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.code <= CODE_SEARCH;
            st_q.hold <= '0;
            st_q.pat  <= PAT_DARK;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/port_led_phase.sv
module port_led_phase
    import port_led_pkg::*;
#(
    parameter int SLOW_ON_MS   = 160,
    parameter int FAST_HALF_MS = 50,
    parameter int CW           = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  pat_e pat_nxt,
    input  pat_e pat_cur,
    input  logic strobe_seen,
    output logic led_n
);
    localparam logic [CW-1:0] SLOW_END  = CW'(SLOW_ON_MS);
    localparam logic [CW-1:0] FAST_HALF = CW'(FAST_HALF_MS);
    localparam logic [CW-1:0] FAST_LAST = CW'(2 * FAST_HALF_MS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          led_n;
    } st_t;

    st_t  st_d, st_q;
    logic restart;

    always_comb begin
        st_d    = st_q;
        restart = (pat_nxt != pat_cur);
        if (tick_ms) begin
            case (pat_nxt)
                PAT_SLOW: begin
                    if (restart || strobe_seen) begin
                        st_d.cnt = '0;
                    end else if (st_q.cnt != SLOW_END) begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                    st_d.led_n = !(st_d.cnt < SLOW_END);
                end
                PAT_FAST: begin
                    if (restart || st_q.cnt == FAST_LAST) begin
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                    st_d.led_n = !(st_d.cnt < FAST_HALF);
                end
                PAT_STEADY: begin
                    st_d.cnt   = '0;
                    st_d.led_n = 1'b0;
                end
                default: begin
                    st_d.cnt   = '0;
                    st_d.led_n = 1'b1;
                end
            endcase
        end
        led_n = st_q.led_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.led_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/port_led_driver.sv
module port_led_driver
    import port_led_pkg::*;
#(
    parameter int SLOW_ON_MS   = 160,
    parameter int FAST_HALF_MS = 50,
    parameter int HOLD_MS      = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       det_strobe,
    input  logic [1:0] state_code,
    output logic       led_n
);
    localparam int CNT_MAX = (SLOW_ON_MS > 2 * FAST_HALF_MS) ? SLOW_ON_MS : 2 * FAST_HALF_MS;
    localparam int CW      = $clog2(CNT_MAX + 1);

    logic strobe_seen;
    pat_e pat_nxt;
    pat_e pat_cur;

    port_led_strobe u_strobe (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_ms     (tick_ms),
        .det_strobe  (det_strobe),
        .strobe_seen (strobe_seen)
    );

    port_led_hold #(
        .HOLD_MS (HOLD_MS)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_ms    (tick_ms),
        .state_code (state_code),
        .pat_nxt    (pat_nxt),
        .pat_cur    (pat_cur)
    );

    port_led_phase #(
        .SLOW_ON_MS   (SLOW_ON_MS),
        .FAST_HALF_MS (FAST_HALF_MS),
        .CW           (CW)
    ) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_ms     (tick_ms),
        .pat_nxt     (pat_nxt),
        .pat_cur     (pat_cur),
        .strobe_seen (strobe_seen),
        .led_n       (led_n)
    );
endmodule

// File: rtl/port_led_chk.sv
module port_led_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_ms,
    input logic       det_strobe,
    input logic [1:0] state_code,
    input logic       led_n
);
    logic [1:0] last_code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_code <= 2'b00;
        end else if (tick_ms) begin
            last_code <= state_code;
        end
    end

    // R1
    reset_dark_chk: assert property (@(posedge clk) !rst_n |=> led_n);

    // R7
    only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_ms |=> $stable(led_n));

    // R4
    powered_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_ms && state_code == 2'b01) |=> !led_n);

    // R3
    strobe_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_ms && state_code == 2'b00 && det_strobe) |=> !led_n);

    // R8
    fast_entry_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_ms && state_code == 2'b11 && last_code[1] == 1'b0) |=> !led_n);
endmodule

bind port_led_driver port_led_chk u_chk (.*);

// File: tb/port_led_driver_tb.sv
module port_led_driver_tb_top;
    localparam int SLOW_ON = 160;
    localparam int FHALF   = 50;
    localparam int HOLD    = 2000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       det_strobe = 1'b0;
    logic [1:0] state_code = 2'b00;
    logic       led_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int m_code = 0, m_hold = 0, m_pat = 0, m_cnt = 0;
    bit m_pend = 1'b0, m_led_n = 1'b1;
    bit left_timed = 1'b0;

    always #2 clk = ~clk;

    port_led_driver #(
        .SLOW_ON_MS   (SLOW_ON),
        .FAST_HALF_MS (FHALF),
        .HOLD_MS      (HOLD)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_ms    (tick_ms),
        .det_strobe (det_strobe),
        .state_code (state_code),
        .led_n      (led_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s led_n actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // pattern codes of the model: 0 dark, 1 slow, 2 steady, 3 fast
    function automatic int pat_of(input int code, input int hold);
        case (code)
            0: return 1;
            1: return 2;
            3: return 3;
            default: return (hold == HOLD) ? 1 : 3;
        endcase
    endfunction

    task automatic one_tick(input int code, input int gap, input bit s_before, input bit s_on);
        int npat;
        bit strobe;
        bit changed;
        bit reentry;
        string req;
        state_code = 2'(code);
        for (int i = 0; i < gap; i++) begin
            det_strobe = s_before && (i == 0);
            if (det_strobe) m_pend = 1'b1;
            @(negedge clk);
            det_strobe = 1'b0;
            chk(led_n == m_led_n, "R7", led_n, m_led_n);
        end
        tick_ms = 1'b1;
        det_strobe = s_on;
        @(negedge clk);
        tick_ms = 1'b0;
        det_strobe = 1'b0;
        strobe = m_pend | s_on;
        reentry = 1'b0;
        if (code == 2) begin
            if (m_code != 2) begin
                reentry = left_timed;
                m_hold = 0;
                left_timed = 1'b1;
            end else if (m_hold < HOLD) begin
                m_hold++;
            end
        end else begin
            m_hold = 0;
        end
        npat = pat_of(code, m_hold);
        changed = (npat != m_pat);
        if (npat == 1) begin
            if (changed || strobe) m_cnt = 0;
            else if (m_cnt < SLOW_ON) m_cnt++;
            m_led_n = !(m_cnt < SLOW_ON);
        end else if (npat == 3) begin
            if (changed || m_cnt == 2 * FHALF - 1) m_cnt = 0;
            else m_cnt++;
            m_led_n = !(m_cnt < FHALF);
        end else begin
            m_cnt = 0;
            m_led_n = 1'b0;
        end
        if (reentry) req = "R9";
        else if (changed) req = "R8";
        else if (npat == 2) req = "R4";
        else if (npat == 3) req = (code == 3) ? "R5" : "R6";
        else if (code == 2) req = "R6";
        else if (strobe) req = "R3";
        else req = "R2";
        m_code = code;
        m_pat = npat;
        m_pend = 1'b0;
        chk(led_n == m_led_n, req, led_n, m_led_n);
    endtask

    initial begin
        while (cycles < 190000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20231));
        repeat (3) @(negedge clk);
        chk(led_n == 1'b1, "R1", led_n, 1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(led_n == 1'b1, "R1", led_n, 1);

        // searching with strobes every 320 ticks
        for (int t = 0; t < 700; t++) one_tick(0, 1, (t % 320) == 319, 1'b0);
        // strobe on the tick cycle itself
        one_tick(0, 1, 1'b0, 1'b1);
        for (int t = 0; t < 200; t++) one_tick(0, 1, 1'b0, 1'b0);
        // R7: code change between ticks shows only at the tick
        state_code = 2'b01;
        repeat (3) @(negedge clk);
        chk(led_n == 1'b1, "R7", led_n, 1);
        one_tick(1, 1, 1'b0, 1'b0);
        chk(led_n == 1'b0, "R4", led_n, 0);
        for (int t = 0; t < 20; t++) one_tick(1, 2, 1'b1, 1'b0);
        // latched fault past the hold time
        for (int t = 0; t < HOLD + 150; t++) one_tick(3, 1, 1'b0, 1'b0);
        // timed fault expiry
        for (int t = 0; t < HOLD + 200; t++) one_tick(2, 1, 1'b0, 1'b0);
        chk(led_n == m_led_n && m_pat == 1, "R6", led_n, m_led_n);
        // re-entry of timed fault
        for (int t = 0; t < 5; t++) one_tick(1, 1, 1'b0, 1'b0);
        for (int t = 0; t < 120; t++) one_tick(2, 1, 1'b0, 1'b0);

        for (int s = 0; s < 36; s++) begin
            int code = int'($urandom % 4);
            int len  = ($urandom % 8 == 0) ? HOLD + int'($urandom % 200) : 1 + int'($urandom % 300);
            for (int t = 0; t < len; t++)
                one_tick(code, 1 + int'($urandom % 2), ($urandom % 50) == 0, ($urandom % 60) == 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule